// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block sits between a memory port and the byte-wide transmit input of an Ethernet MAC. Software builds a ring of two-word transmit descriptors in memory, hands each one to hardware by setting its ready flag, and then pulses a start input. The walker reads the descriptor at its current ring position. If the descriptor is ready, the walker reads the buffer word by word and hands the bytes to the MAC one per accepted beat. It marks the final byte of a frame and says whether the MAC must append a checksum. Once the buffer is sent, it writes the descriptor header back with the ready flag cleared and moves on to the next descriptor, or back to the ring start when the wrap flag is set. It keeps walking until it meets a descriptor that is not ready. At that point its busy flag drops.

Two controls bring the ring position back to the ring start. The first is a graceful stop request. This lets the frame in flight finish through the write-back of its final descriptor and then raises a stop event, which a clear pulse lowers. The second is dropping the controller enable, which aborts at once. A descriptor whose length is zero or longer than the configured maximum sends nothing but is still handed back to software.

The walker is a single state machine with six states:
- `W_IDLE` waits for the busy flag or for a pending stop.
- `W_HDR` reads the header.
- `W_PTR` reads the buffer address.
- `W_RDW` reads one buffer word.
- `W_SEND` presents bytes.
- `W_WB` writes the header back.

Its transitions are:
- IDLE→HDR when busy and no stop is pending.
- HDR→PTR on a ready header, and HDR→IDLE on a header that is not ready.
- PTR→RDW on a valid length, and PTR→WB on a bad length.
- RDW→SEND on each word read.
- SEND→RDW after the fourth lane of a word.
- SEND→WB after the final byte.
- WB→HDR to continue.
- WB→IDLE when a pending stop meets a frame end.
- Any state→IDLE when the enable is low.

Top module: `tx_desc_walker`

## Requirements
- R1: A one-cycle `tx_kick` while `ctrl_en` is high sets `active` on the next edge. The walker then reads the header at the current ring position, which after reset is `ring_base`.
- R2: A descriptor is two 32-bit words at an 8-byte-aligned address. Word 0 holds the length in bits 15:0 and status in bits 31:16, with ready at bit 31, wrap at bit 30, frame-end at bit 29 and checksum-request at bit 28. Word 1 at +4 holds a word-aligned buffer address.
- R3: Exactly `length` bytes are presented, in memory order, lowest byte lane of each word first. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R4: `tx_last` is high only on the final byte of a descriptor whose frame-end bit is set. `tx_crc` is high on that byte exactly when the descriptor's checksum-request bit is set.
- R5: After a descriptor is finished, word 0 is rewritten with bit 31 cleared and every other bit unchanged. This happens before the next header read.
- R6: The next header read is at +8, or at `ring_base` when wrap is set. A lone self-wrapping descriptor is therefore sent once.
- R7: A header without ready makes `active` fall with no bytes and no write. The ring position is kept, so the next kick re-reads the same address. `active` never falls while a write-back is pending.
- R8: A descriptor with length 0 or length above `max_len` presents no bytes but is still written back with ready cleared.
- R9: A `stop_req` pulse lets the current frame finish through the write-back of its frame-end descriptor. The walker then sets `stop_evt`, clears `active`, leaves later ready descriptors untouched and returns the ring position to `ring_base`. `stop_evt_clr` lowers `stop_evt`.
- R10: While `ctrl_en` is low, `mem_req` and `tx_valid` are low, `active` is low, kicks are ignored and the ring position returns to `ring_base`.
- R11: A memory request holds its address and direction until `mem_ready` accepts it. Stalls on either side change no data.
- R12: Out of reset, `active`, `stop_evt`, `mem_req` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_en | input | 1 | Controller enable; low aborts and rewinds the ring |
| tx_kick | input | 1 | Pulse: start walking the ring |
| stop_req | input | 1 | Pulse: graceful stop after the current frame |
| stop_evt_clr | input | 1 | Pulse: clear the stop event |
| ring_base | input | 32 | Byte address of the first descriptor |
| max_len | input | 16 | Largest buffer length accepted |
| active | output | 1 | Walker busy flag |
| stop_evt | output | 1 | Graceful stop completed |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte valid toward the MAC |
| tx_data | output | 8 | Byte toward the MAC |
| tx_last | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | MAC must append a checksum after this frame |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
Most internal faults in this walker surface in memory within a single descriptor. A ring position that advances wrongly shows up in the next header address. A lost write-back leaves bit 31 set in memory, and the lone-wrap case then sends the buffer twice. An off-by-one in the byte counter or lane shows in the captured byte stream or in the position of `tx_last` within the same frame. A mishandled stop or enable shows in the first header address read after the next kick.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_HDR,
        W_PTR,
        W_RDW,
        W_SEND,
        W_WB
    } walk_t;

    // status flag positions inside descriptor word 0
    localparam int FLAG_RDY  = 31;
    localparam int FLAG_WRAP = 30;
    localparam int FLAG_END  = 29;
    localparam int FLAG_CRC  = 28;

    localparam int DESC_BYTES = 8;
    localparam int PTR_OFFSET = 4;

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          go_base,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (go_base) begin
            off_q <= '0;
        end else if (step) begin
            off_q <= wrap ? '0 : off_q + AW'(STEP);
        end
    end

    assign cur = base + off_q;

endmodule

// File: rtl/txd_byte_lane.sv
module txd_byte_lane #(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word,
    input  logic          clr,
    input  logic          take,
    output logic [7:0]    byte_o,
    output logic          lane_end,
    output logic [LW-1:0] cnt
);

    localparam int NB = DW / 8;
    localparam int LB = (NB > 1) ? $clog2(NB) : 1;

    logic [DW-1:0] word_q;
    logic [LB-1:0] lane_q;
    logic [LW-1:0] cnt_q;
    logic [7:0]    lanes [NB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            lane_q <= '0;
        end else if (load) begin
            word_q <= word;
            lane_q <= '0;
        end else if (take) begin
            lane_q <= lane_q + LB'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word_q[8*g +: 8];
    end

    assign byte_o   = lanes[lane_q];
    assign lane_end = (lane_q == LB'(NB - 1));
    assign cnt      = cnt_q;

endmodule

// File: rtl/txd_walk_ctl.sv
module txd_walk_ctl
    import txd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          kick,
    input  logic          stop_req,
    input  logic          stop_clr,
    input  logic [LW-1:0] max_len,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic          tx_ready,
    input  logic [LW-1:0] sent_cnt,
    input  logic          lane_end,
    output walk_t         state_o,
    output logic [DW-1:0] hdr_o,
    output logic [AW-1:0] buf_addr_o,
    output logic          mem_req_o,
    output logic          active_o,
    output logic          stop_evt_o,
    output logic          go_base_o,
    output logic          step_o,
    output logic          wrap_o,
    output logic          word_load_o,
    output logic          cnt_clr_o,
    output logic          take_o,
    output logic          tx_valid_o,
    output logic          tx_last_o,
    output logic          tx_crc_o
);

    walk_t         st_q, st_d;
    logic [DW-1:0] hdr_q;
    logic [AW-1:0] buf_q;
    logic          active_q, pend_q, evt_q;

    logic          acc;
    logic          bad_len;
    logic          final_byte;
    logic          do_stop;
    logic [LW-1:0] len;

    assign len        = hdr_q[LW-1:0];
    assign bad_len    = (len == '0) || (len > max_len);
    assign final_byte = (sent_cnt == len - LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= W_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE: begin
                if (!pend_q && active_q) begin
                    st_d = W_HDR;
                end
            end
            W_HDR: begin
                if (acc) begin
                    st_d = mem_rdata[FLAG_RDY] ? W_PTR : W_IDLE;
                end
            end
            W_PTR: begin
                if (acc) begin
                    st_d = bad_len ? W_WB : W_RDW;
                end
            end
            W_RDW: begin
                if (acc) begin
                    st_d = W_SEND;
                end
            end
            W_SEND: begin
                if (tx_ready) begin
                    if (final_byte) begin
                        st_d = W_WB;
                    end else if (lane_end) begin
                        st_d = W_RDW;
                    end
                end
            end
            W_WB: begin
                if (acc) begin
                    st_d = (pend_q && hdr_q[FLAG_END]) ? W_IDLE : W_HDR;
                end
            end
            default: st_d = W_IDLE;
        endcase
        if (!en) begin
            st_d = W_IDLE;
        end
    end

    // outputs
    always_comb begin
        mem_req_o  = 1'b0;
        tx_valid_o = 1'b0;
        unique case (st_q)
            W_HDR, W_PTR, W_RDW, W_WB: mem_req_o  = en;
            W_SEND:                    tx_valid_o = en;
            default: ;
        endcase
        acc         = mem_req_o && mem_ready;
        do_stop     = en && pend_q &&
                      ((st_q == W_IDLE) ||
                       ((st_q == W_WB) && acc && hdr_q[FLAG_END]));
        go_base_o   = !en || do_stop;
        step_o      = (st_q == W_WB) && acc && !do_stop;
        wrap_o      = hdr_q[FLAG_WRAP];
        word_load_o = (st_q == W_RDW) && acc;
        cnt_clr_o   = (st_q == W_PTR) && acc;
        take_o      = tx_valid_o && tx_ready;
        tx_last_o   = tx_valid_o && hdr_q[FLAG_END] && final_byte;
        tx_crc_o    = tx_last_o && hdr_q[FLAG_CRC];
    end

    // descriptor and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
            buf_q <= '0;
        end else begin
            if ((st_q == W_HDR) && acc) begin
                hdr_q <= mem_rdata;
            end
            if ((st_q == W_PTR) && acc) begin
                buf_q <= AW'({mem_rdata[AW-1:2], 2'b00});
            end else if ((st_q == W_RDW) && acc) begin
                buf_q <= buf_q + AW'(4);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            evt_q    <= 1'b0;
        end else begin
            if (!en) begin
                active_q <= 1'b0;
            end else if (kick) begin
                active_q <= 1'b1;
            end else if (((st_q == W_HDR) && acc && !mem_rdata[FLAG_RDY]) || do_stop) begin
                active_q <= 1'b0;
            end

            if (!en) begin
                pend_q <= 1'b0;
            end else if (stop_req) begin
                pend_q <= 1'b1;
            end else if (do_stop) begin
                pend_q <= 1'b0;
            end

            if (do_stop) begin
                evt_q <= 1'b1;
            end else if (stop_clr) begin
                evt_q <= 1'b0;
            end
        end
    end

    assign state_o    = st_q;
    assign hdr_o      = hdr_q;
    assign buf_addr_o = buf_q;
    assign active_o   = active_q;
    assign stop_evt_o = evt_q;

endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import txd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_en,
    input  logic          tx_kick,
    input  logic          stop_req,
    input  logic          stop_evt_clr,
    input  logic [AW-1:0] ring_base,
    input  logic [LW-1:0] max_len,
    output logic          active,
    output logic          stop_evt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_crc,
    input  logic          tx_ready
);

    walk_t         walk_state;
    logic [DW-1:0] hdr;
    logic [AW-1:0] buf_addr;
    logic [AW-1:0] cur_desc;
    logic          go_base, step, wrap;
    logic          word_load, cnt_clr, take;
    logic          lane_end;
    logic [LW-1:0] sent_cnt;

    txd_walk_ctl #(.AW(AW), .DW(DW), .LW(LW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_en),
        .kick        (tx_kick),
        .stop_req    (stop_req),
        .stop_clr    (stop_evt_clr),
        .max_len     (max_len),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .tx_ready    (tx_ready),
        .sent_cnt    (sent_cnt),
        .lane_end    (lane_end),
        .state_o     (walk_state),
        .hdr_o       (hdr),
        .buf_addr_o  (buf_addr),
        .mem_req_o   (mem_req),
        .active_o    (active),
        .stop_evt_o  (stop_evt),
        .go_base_o   (go_base),
        .step_o      (step),
        .wrap_o      (wrap),
        .word_load_o (word_load),
        .cnt_clr_o   (cnt_clr),
        .take_o      (take),
        .tx_valid_o  (tx_valid),
        .tx_last_o   (tx_last),
        .tx_crc_o    (tx_crc)
    );

    txd_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (ring_base),
        .go_base (go_base),
        .step    (step),
        .wrap    (wrap),
        .cur     (cur_desc)
    );

    txd_byte_lane #(.DW(DW), .LW(LW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (word_load),
        .word     (mem_rdata),
        .clr      (cnt_clr),
        .take     (take),
        .byte_o   (tx_data),
        .lane_end (lane_end),
        .cnt      (sent_cnt)
    );

    // memory address and write path
    always_comb begin
        unique case (walk_state)
            W_PTR:   mem_addr = cur_desc + AW'(PTR_OFFSET);
            W_RDW:   mem_addr = buf_addr;
            default: mem_addr = cur_desc;
        endcase
        mem_we    = mem_req && (walk_state == W_WB);
        mem_wdata = hdr & ~(DW'(1) << FLAG_RDY);
    end

endmodule

// File: rtl/txd_walk_chk.sv
module txd_walk_chk
    import txd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en,
    input logic          tx_kick,
    input logic          active,
    input logic          stop_evt,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input walk_t         walk_state
);

    // R10: disabled walker is silent
    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (!mem_req && !tx_valid));

    // R3: byte held under backpressure
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && ctrl_en) |=>
            (!ctrl_en || (tx_valid && $stable(tx_data) && $stable(tx_last))));

    // R11: memory request held until accepted
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && ctrl_en) |=>
            (!ctrl_en || (mem_req && $stable(mem_addr) && $stable(mem_we))));

    // R5: write-back always hands the descriptor back
    p_wb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[FLAG_RDY]);

    // R7: busy flag falls only at a header read, a write-back or in idle
    p_late_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && $past(ctrl_en)) |->
            ($past(walk_state) == W_HDR || $past(walk_state) == W_WB ||
             $past(walk_state) == W_IDLE));

    // R9: stop event comes with the busy flag low
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_evt) && !$past(tx_kick)) |-> !active);

endmodule

bind tx_desc_walker txd_walk_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .tx_kick    (tx_kick),
    .active     (active),
    .stop_evt   (stop_evt),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .walk_state (walk_state)
);

// File: tb/tx_desc_walker_tb_top.sv
module tx_desc_walker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE  = 'h40;
    localparam int BUFA  = 'h200;
    localparam int BUFB  = 'h240;
    localparam int MAXL  = 64;
    localparam int NVEC  = 8;
    // [18] stall, [17] checksum request, [16] wrap, [15:0] length
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 16'd1},
        {1'b0, 1'b1, 1'b0, 16'd4},
        {1'b0, 1'b0, 1'b1, 16'd5},
        {1'b1, 1'b1, 1'b0, 16'd13},
        {1'b1, 1'b0, 1'b1, 16'd64},
        {1'b0, 1'b0, 1'b0, 16'd0},
        {1'b0, 1'b1, 1'b0, 16'd65},
        {1'b1, 1'b1, 1'b1, 16'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b1;
    logic        tx_kick = 1'b0;
    logic        stop_req = 1'b0;
    logic        stop_evt_clr = 1'b0;
    logic [31:0] ring_base = BASE;
    logic [15:0] max_len = MAXL;
    logic        active, stop_evt, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic        tx_valid, tx_last, tx_crc;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    logic [31:0] mem [256];
    logic [7:0]  cap_data [512];
    logic        cap_last [512];
    logic        cap_crc  [512];
    int          hdr_log  [128];
    int          n_cap = 0, n_hdr = 0, n_wr = 0, cyc = 0;
    logic        hw_en = 1'b0;
    int          hw_addr = 0;
    logic [31:0] hw_data = '0;
    logic        stall = 1'b0;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_desc_walker dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_kick(tx_kick),
        .stop_req(stop_req), .stop_evt_clr(stop_evt_clr), .ring_base(ring_base),
        .max_len(max_len), .active(active), .stop_evt(stop_evt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_crc(tx_crc), .tx_ready(tx_ready)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    // memory model, sink and logs: all updated away from the rising edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_ready = stall ? ((cyc % 2) == 0) : 1'b1;
        tx_ready  = stall ? ((cyc % 4) < 2)  : 1'b1;
        if (hw_en) mem[hw_addr[9:2]] = hw_data;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                n_wr = n_wr + 1;
            end else if (mem_addr < BUFA && mem_addr[2] == 1'b0) begin
                hdr_log[n_hdr % 128] = int'(mem_addr);
                n_hdr = n_hdr + 1;
            end
        end
        if (rst_n && tx_valid && tx_ready) begin
            cap_data[n_cap % 512] = tx_data;
            cap_last[n_cap % 512] = tx_last;
            cap_crc[n_cap % 512]  = tx_crc;
            n_cap = n_cap + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mw(input int a, input logic [31:0] d);
        hw_addr = a;
        hw_data = d;
        hw_en = 1'b1;
        @(negedge clk);
        #1;
        hw_en = 1'b0;
    endtask

    task automatic kick();
        tick();
        tx_kick = 1'b1;
        tick();
        tx_kick = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (active && t < 5000) begin
            @(negedge clk);
            t++;
        end
        #1;
        check(!active, "R1", "walker finished", active, 0);
    endtask

    task automatic rehome();
        tick();
        ctrl_en = 1'b0;
        tick();
        tick();
        ctrl_en = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int k, input int j);
        return 8'((k * 37 + j * 11 + 3) & 255);
    endfunction

    task automatic run_tests();
        int c0, h0, w0;
        logic [31:0] h;
        // reset state (R12)
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(!active && !stop_evt, "R12", "flags after reset", {active, stop_evt}, 0);
        check(!mem_req && !tx_valid, "R12", "bus after reset", {mem_req, tx_valid}, 0);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            int len, expn, mism, badf;
            logic wr, cr, stl;
            len = int'(VEC[k][15:0]);
            wr  = VEC[k][16];
            cr  = VEC[k][17];
            stl = VEC[k][18];
            rehome();
            stall = stl;
            for (int w = 0; w < (len + 3) / 4; w++) begin
                mw(BUFA + 4 * w, {pat(k, 4*w+3), pat(k, 4*w+2), pat(k, 4*w+1), pat(k, 4*w)});
            end
            h = {1'b1, wr, 1'b1, cr, 12'h100, 16'(len)};
            mw(BASE, h);
            mw(BASE + 4, BUFA);
            mw(BASE + 8, 32'h0);
            mw(BASE + 12, BUFA);
            c0 = n_cap;
            h0 = n_hdr;
            kick();
            check(active, "R1", "active after kick", active, 1);
            wait_done();
            expn = (len == 0 || len > MAXL) ? 0 : len;
            if (expn == 0) check(n_cap - c0 == 0, "R8", "bytes for bad length", n_cap - c0, 0);
            else           check(n_cap - c0 == expn, "R3", "byte count", n_cap - c0, expn);
            mism = 0;
            badf = 0;
            for (int i = 0; i < expn; i++) begin
                if (cap_data[(c0 + i) % 512] != pat(k, i)) mism++;
                if (cap_last[(c0 + i) % 512] != (i == expn - 1)) badf++;
                if (cap_crc[(c0 + i) % 512] != (cr && (i == expn - 1))) badf++;
            end
            check(mism == 0, stl ? "R11" : "R3", "byte values", mism, 0);
            check(badf == 0, "R4", "end and checksum marks", badf, 0);
            check(mem[BASE >> 2] == (h & 32'h7FFF_FFFF), "R5", "header write-back",
                  mem[BASE >> 2], h & 32'h7FFF_FFFF);
            check(n_hdr - h0 == 2 && hdr_log[h0 % 128] == BASE, "R2", "header reads",
                  hdr_log[h0 % 128], BASE);
            check(hdr_log[(h0 + 1) % 128] == (wr ? BASE : BASE + 8), "R6", "next header address",
                  hdr_log[(h0 + 1) % 128], wr ? BASE : BASE + 8);
        end
        stall = 1'b0;

        // two descriptors form one frame (R2, R4, R5)
        rehome();
        mw(BUFA, 32'h33221100);
        mw(BUFB, 32'h0000BBAA);
        mw(BASE, 32'h8000_0003);
        mw(BASE + 4, BUFA);
        mw(BASE + 8, 32'hB000_0002);
        mw(BASE + 12, BUFB);
        mw(BASE + 16, 32'h0);
        mw(BASE + 20, BUFA);
        c0 = n_cap;
        kick();
        wait_done();
        check(n_cap - c0 == 5, "R2", "chained byte count", n_cap - c0, 5);
        check({cap_data[c0 % 512], cap_data[(c0+2) % 512], cap_data[(c0+3) % 512],
               cap_data[(c0+4) % 512]} == 32'h0022AABB, "R2", "chained bytes",
              {cap_data[c0 % 512], cap_data[(c0+2) % 512], cap_data[(c0+3) % 512],
               cap_data[(c0+4) % 512]}, 32'h0022AABB);
        check(!cap_last[(c0+2) % 512] && cap_last[(c0+4) % 512] && cap_crc[(c0+4) % 512],
              "R4", "end mark only on frame end", {cap_last[(c0+2) % 512], cap_last[(c0+4) % 512]}, 1);
        check(mem[(BASE >> 2)] == 32'h0000_0003 && mem[(BASE >> 2) + 2] == 32'h3000_0002,
              "R5", "both headers returned", mem[(BASE >> 2) + 2], 32'h3000_0002);

        // not-ready header keeps position (R7)
        c0 = n_cap; h0 = n_hdr; w0 = n_wr;
        kick();
        wait_done();
        check(n_hdr - h0 == 1 && hdr_log[h0 % 128] == BASE + 16, "R7", "idle re-read address",
              hdr_log[h0 % 128], BASE + 16);
        check(n_cap == c0 && n_wr == w0, "R7", "no bytes or writes", n_cap - c0 + n_wr - w0, 0);
        mw(BASE + 16, 32'hE000_0002);
        h0 = n_hdr; c0 = n_cap;
        kick();
        wait_done();
        check(hdr_log[h0 % 128] == BASE + 16 && n_cap - c0 == 2, "R7", "retry after refill",
              hdr_log[h0 % 128], BASE + 16);
        check(hdr_log[(h0 + 1) % 128] == BASE, "R6", "wrap back to base",
              hdr_log[(h0 + 1) % 128], BASE);

        // enable low (R10)
        mw(BASE, 32'hA000_0001);
        kick();
        wait_done();
        tick();
        ctrl_en = 1'b0;
        kick();
        check(!active && !mem_req && !tx_valid, "R10", "silent while disabled",
              {active, mem_req, tx_valid}, 0);
        ctrl_en = 1'b1;
        tick();
        tick();
        check(!active, "R10", "kick ignored while disabled", active, 0);
        mw(BASE, 32'hA000_0002);
        mw(BASE + 8, 32'h0);
        h0 = n_hdr; c0 = n_cap;
        kick();
        wait_done();
        check(hdr_log[h0 % 128] == BASE && n_cap - c0 == 2, "R10", "position back at base",
              hdr_log[h0 % 128], BASE);

        // graceful stop (R9)
        rehome();
        stall = 1'b1;
        mw(BASE, 32'h8000_0006);
        mw(BASE + 4, BUFA);
        mw(BASE + 8, 32'hA000_0003);
        mw(BASE + 12, BUFB);
        mw(BASE + 16, 32'hA000_0002);
        mw(BASE + 20, BUFA);
        c0 = n_cap;
        kick();
        for (int t = 0; t < 2000 && n_cap == c0; t++) @(negedge clk);
        tick();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        wait_done();
        check(n_cap - c0 == 9, "R9", "frame finished before stop", n_cap - c0, 9);
        check(stop_evt, "R9", "stop event set", stop_evt, 1);
        check(mem[(BASE >> 2) + 4][31] && !mem[(BASE >> 2) + 2][31], "R9",
              "later descriptor untouched", mem[(BASE >> 2) + 4], 32'hA000_0002);
        tick();
        stop_evt_clr = 1'b1;
        tick();
        stop_evt_clr = 1'b0;
        check(!stop_evt, "R9", "stop event cleared", stop_evt, 0);
        stall = 1'b0;
        h0 = n_hdr; c0 = n_cap;
        kick();
        wait_done();
        check(hdr_log[h0 % 128] == BASE && n_cap == c0, "R9", "position rewound by stop",
              hdr_log[h0 % 128], BASE);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(negedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule